// File: doc/BRIEF.md
# Dual-Parity Stripe Syndrome Generator

This block computes both parity words of a dual-parity disk stripe, one column at a time. For every data disk in the stripe, one data word arrives for the current column offset, and the highest-numbered data disk comes first. The block then emits two results for that column. The first is the row parity, which is the XOR of all data words. The second is the Reed-Solomon syndrome over GF(2^8), which weights each disk by a power of the field generator.

Each data word holds `LANES` byte lanes, and all lanes are processed in parallel in a single cycle. The syndrome uses Horner's rule. The first word of a column loads both accumulators directly. For each word after that, every byte lane of the syndrome is multiplied by two in the field and then XORed with the incoming data byte. The multiply by two is a one-bit left shift. When the byte's top bit was set, the reduction constant 0x1d is folded in, which corresponds to the generator polynomial x^8+x^4+x^3+x^2+1.

Input is a valid/ready stream carrying a data word plus flags that mark the first and last disk of a column. Output is a valid/ready pair that carries the finished row parity and syndrome word.

Top module: `pq_syndrome_gen`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1, and `out_p` and `out_q` are all zeros.
- R2: An accepted word with `in_first`=1 loads both accumulators with the word itself. A stripe of one data disk (`in_first`=1 and `in_last`=1 on the same word) therefore gives `out_p` = `out_q` = that word.
- R3: `out_p` is the XOR of every word accepted from the column's first word through its last word.
- R4: For each accepted word after the first, the syndrome is updated as Q = mul2(Q) XOR data. The update is applied independently in each byte lane (lane k is bits 8k+7..8k), and no carry crosses between lanes.
- R5: mul2(b) is b shifted left by one bit, truncated to 8 bits, and XORed with 0x1d when bit 7 of b was 1. Examples: mul2(0x80)=0x1d, mul2(0xff)=0xe3, mul2(0x7f)=0xfe.
- R6: `out_valid` rises in the cycle after the word with `in_last`=1 is accepted. It stays high, with `out_p` and `out_q` unchanged, until a cycle in which `out_ready` is 1.
- R7: `in_ready` is 0 whenever `out_valid` is 1. An offered word is held off, not lost, and is accepted once the result has been taken.
- R8: An `in_first` word arriving in the middle of a column restarts accumulation. Words accepted before it do not affect the results.
- R9: A cycle with `in_valid`=0 has no effect on the accumulators, whatever the values of `in_data`, `in_first` and `in_last`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Block can take an input word |
| in_data | input | LANES*8 | Data word from one disk |
| in_first | input | 1 | Word is the first (highest-numbered) disk of a column |
| in_last | input | 1 | Word is the last (disk 0) of a column |
| out_valid | output | 1 | Parity and syndrome words available |
| out_ready | input | 1 | Consumer takes the result |
| out_p | output | LANES*8 | Row parity word |
| out_q | output | LANES*8 | Reed-Solomon syndrome word |

## Verification
A wrong accumulator state shows only at the end of a column. It appears on `out_p` or `out_q` in the cycle after the last word is accepted, so each column is one observation point. A fault in the field doubling affects only the syndrome lanes whose top bit was set. For this reason, directed columns feed bytes 0x80, 0xff and 0x7f next to ordinary bytes, and the lanes the fault touches can be read off directly. Handshake faults show within one cycle as a stuck or early `out_valid`, or as `in_ready` high while a result is pending. Random columns of one to eight disks are compared against a byte-wise model.

// File: rtl/pq_syndrome_pkg.sv
package pq_syndrome_pkg;
    localparam int BYTE_W = 8;
    // low byte of the GF(2^8) generator x^8+x^4+x^3+x^2+1
    localparam logic [BYTE_W-1:0] GF_REDUCE = 8'h1d;
endpackage

// File: rtl/pq_gf_double.sv
module pq_gf_double
    import pq_syndrome_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_i,
    output logic [BYTE_W-1:0] byte_o
);
    logic [BYTE_W-1:0] sign_mask;

    always_comb begin
        // sign test gives all ones or all zeros
        sign_mask = {BYTE_W{byte_i[BYTE_W-1]}};
        byte_o    = {byte_i[BYTE_W-2:0], 1'b0} ^ (sign_mask & GF_REDUCE);
    end

    // bit 0 can only come from the reduction constant
    always_comb begin
        assert_low_bit_R5: assert (byte_o[0] == byte_i[BYTE_W-1]);
    end
endmodule

// File: rtl/pq_lane.sv
module pq_lane
    import pq_syndrome_pkg::*;
(
    input  logic              first_i,
    input  logic [BYTE_W-1:0] data_i,
    input  logic [BYTE_W-1:0] p_i,
    input  logic [BYTE_W-1:0] q_i,
    output logic [BYTE_W-1:0] p_o,
    output logic [BYTE_W-1:0] q_o
);
    logic [BYTE_W-1:0] q_dbl;

    pq_gf_double dbl_i (
        .byte_i (q_i),
        .byte_o (q_dbl)
    );

    always_comb begin
        if (first_i) begin
            p_o = data_i;
            q_o = data_i;
        end else begin
            p_o = p_i ^ data_i;
            q_o = q_dbl ^ data_i;
        end
    end
endmodule

// File: rtl/pq_syndrome_gen.sv
module pq_syndrome_gen
    import pq_syndrome_pkg::*;
#(
    parameter int LANES = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [LANES*BYTE_W-1:0] in_data,
    input  logic                    in_first,
    input  logic                    in_last,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [LANES*BYTE_W-1:0] out_p,
    output logic [LANES*BYTE_W-1:0] out_q
);
    localparam int WORD_W = LANES * BYTE_W;

    typedef struct packed {
        logic [WORD_W-1:0] p;
        logic [WORD_W-1:0] q;
        logic              vld;
    } acc_state_t;

    acc_state_t st_d, st_q;
    logic [WORD_W-1:0] p_step, q_step;
    logic accept;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        pq_lane lane_i (
            .first_i (in_first),
            .data_i  (in_data[g*BYTE_W +: BYTE_W]),
            .p_i     (st_q.p[g*BYTE_W +: BYTE_W]),
            .q_i     (st_q.q[g*BYTE_W +: BYTE_W]),
            .p_o     (p_step[g*BYTE_W +: BYTE_W]),
            .q_o     (q_step[g*BYTE_W +: BYTE_W])
        );
    end

    assign in_ready  = !st_q.vld;
    assign accept    = in_valid && in_ready;
    assign out_valid = st_q.vld;
    assign out_p     = st_q.p;
    assign out_q     = st_q.q;

    always_comb begin
        st_d = st_q;
        if (st_q.vld && out_ready) begin
            st_d.vld = 1'b0;
        end
        if (accept) begin
            st_d.p = p_step;
            st_d.q = q_step;
            if (in_last) begin
                st_d.vld = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assert_ready_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    assert_result_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_p) && $stable(out_q)));

    assert_valid_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(in_valid && in_ready && in_last));

    assert_single_disk_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_first && in_last) |=>
            (out_p == $past(in_data) && out_q == $past(in_data)));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_p) && $stable(out_q)));
endmodule

// File: tb/pq_syndrome_gen_tb_top.sv
module pq_syndrome_gen_tb_top;
    localparam int LANES = 16;
    localparam int W = LANES * 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [W-1:0] in_data = '0;
    logic in_first = 1'b0;
    logic in_last = 1'b0;
    logic out_valid;
    logic out_ready = 1'b0;
    logic [W-1:0] out_p, out_q;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] words [8];
    logic [W-1:0] exp_p, exp_q;

    always #10 clk = ~clk;

    pq_syndrome_gen #(.LANES(LANES)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_first(in_first), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_p(out_p), .out_q(out_q)
    );

    function automatic logic [7:0] ref_dbl(input logic [7:0] b);
        logic [8:0] t;
        t = {b, 1'b0};
        if (b >= 8'd128) return t[7:0] ^ 8'h1d;
        return t[7:0];
    endfunction

    task automatic build_ref(input int n);
        exp_p = words[0];
        exp_q = words[0];
        for (int i = 1; i < n; i++) begin
            exp_p = exp_p ^ words[i];
            for (int k = 0; k < LANES; k++)
                exp_q[k*8 +: 8] = ref_dbl(exp_q[k*8 +: 8]) ^ words[i][k*8 +: 8];
        end
    endtask

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // called at a negedge; returns at the negedge after acceptance
    task automatic push(input logic [W-1:0] d, input logic f, input logic l);
        in_data = d; in_first = f; in_last = l; in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic take(input string req);
        chk({req, " valid"}, W'(out_valid), W'(1));
        chk("R7 ready low", W'(in_ready), W'(0));
        chk({req, " P"}, out_p, exp_p);
        chk({req, " Q"}, out_q, exp_q);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        chk("R6 valid drops", W'(out_valid), W'(0));
    endtask

    task automatic send_stripe(input int n, input string req);
        build_ref(n);
        for (int i = 0; i < n; i++) push(words[i], i == 0, i == n - 1);
        in_valid = 1'b0;
        take(req);
    endtask

    task automatic fill_lanes(input int idx, input logic [7:0] b);
        for (int k = 0; k < LANES; k++) words[idx][k*8 +: 8] = b;
    endtask

    task automatic t_reset;
        chk("R1 out_valid", W'(out_valid), W'(0));
        chk("R1 in_ready", W'(in_ready), W'(1));
        chk("R1 out_p", out_p, '0);
        chk("R1 out_q", out_q, '0);
    endtask

    task automatic t_single;
        words[0] = {4{32'hdead_beef}};
        send_stripe(1, "R2 one-disk");
    endtask

    task automatic t_mul2_corners;
        fill_lanes(0, 8'h80); fill_lanes(1, 8'h00);
        send_stripe(2, "R5 0x80");
        chk("R5 lane 0x80", W'(exp_q[7:0]), W'(8'h1d));
        fill_lanes(0, 8'hff);
        send_stripe(2, "R5 0xff");
        chk("R5 lane 0xff", W'(exp_q[7:0]), W'(8'he3));
        fill_lanes(0, 8'h7f);
        send_stripe(2, "R5 0x7f");
    endtask

    task automatic t_lane_indep;
        for (int k = 0; k < LANES; k++) begin
            words[0][k*8 +: 8] = (k % 2 == 0) ? 8'h80 : 8'h01;
            words[1][k*8 +: 8] = 8'(k);
            words[2][k*8 +: 8] = 8'hc3;
        end
        send_stripe(3, "R4 lanes");
    endtask

    task automatic t_random;
        for (int r = 0; r < 40; r++) begin
            int n;
            n = 1 + int'($urandom % 8);
            for (int i = 0; i < n; i++)
                words[i] = {$urandom, $urandom, $urandom, $urandom};
            send_stripe(n, "R3 R4 random");
        end
    endtask

    task automatic t_restart;
        push({4{32'h1234_5678}}, 1'b1, 1'b0);
        push({4{32'h0f0f_0f0f}}, 1'b0, 1'b0);
        for (int i = 0; i < 3; i++) words[i] = {$urandom, $urandom, $urandom, $urandom};
        send_stripe(3, "R8 restart");
    endtask

    task automatic t_idle_ignored;
        for (int i = 0; i < 3; i++) words[i] = {$urandom, $urandom, $urandom, $urandom};
        build_ref(3);
        push(words[0], 1'b1, 1'b0);
        in_valid = 1'b0; in_data = '1; in_first = 1'b1; in_last = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9 no result", W'(out_valid), W'(0));
        push(words[1], 1'b0, 1'b0);
        in_valid = 1'b0; in_data = {4{32'h5a5a_a5a5}}; in_first = 1'b0; in_last = 1'b0;
        repeat (2) @(negedge clk);
        push(words[2], 1'b0, 1'b1);
        in_valid = 1'b0;
        take("R9 idle");
    endtask

    task automatic t_backpressure;
        logic [W-1:0] hp, hq;
        for (int i = 0; i < 2; i++) words[i] = {$urandom, $urandom, $urandom, $urandom};
        build_ref(2);
        push(words[0], 1'b1, 1'b0);
        push(words[1], 1'b0, 1'b1);
        hp = exp_p; hq = exp_q;
        // offer next column's first word while result is pending
        in_data = {4{32'hcafe_f00d}}; in_first = 1'b1; in_last = 1'b1; in_valid = 1'b1;
        for (int c = 0; c < 3; c++) begin
            chk("R6 held valid", W'(out_valid), W'(1));
            chk("R7 blocked", W'(in_ready), W'(0));
            chk("R6 held P", out_p, hp);
            chk("R6 held Q", out_q, hq);
            @(negedge clk);
        end
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        chk("R7 released", W'(in_ready), W'(1));
        @(negedge clk);
        in_valid = 1'b0;
        exp_p = {4{32'hcafe_f00d}}; exp_q = exp_p;
        take("R7 held word");
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_mul2_corners();
        t_lane_indep();
        t_restart();
        t_idle_ignored();
        t_backpressure();
        t_random();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule